// File: doc/BRIEF.md
# Stepwise I2C Bus Master

This block is an I2C bus master that software advances one bus phase at a time. A small write-only register port takes command requests: a START, a repeated START, a STOP and an interrupt clear. A write to the data register launches one byte on the bus, which is either the address-plus-direction byte or a payload byte. The block makes every SCL pulse and every START and STOP condition itself. It samples the slave's acknowledge into a status output and raises a sticky interrupt flag at the end of each phase.

SCL timing comes from a reloadable tick counter. The counter runs only while a phase is in progress. When a byte completes, SCL is left low and the bus stays owned. Software then chooses a repeated START, another byte or a STOP. Both bus lines are modelled as open-drain pins: each has an output enable that pulls the line low and a separate pin-level input.

Top module: `i2c_step_master`

## Requirements
- R1: After reset both output enables are 0 (lines released), `irq_flag`=0, `ack_stat`=0, `cmd_pend`=0 and `busy`=0.
- R2: Writing 1 to bit 0 (START) of register 1 makes SDA fall while SCL is high. One half period later SCL is pulled low. The START bit then self-clears in `cmd_pend`, `irq_flag` is set, and both lines stay driven low.
- R3: Writing register 0 while idle with no command pending sends the 8 written bits MSB first over 8 SCL pulses. During the byte, SDA changes only while SCL is low.
- R4: On a 9th SCL pulse the master releases SDA. It stores the SDA level sampled at the end of that high half in `ack_stat` (0 = acknowledge, 1 = no acknowledge).
- R5: At the end of the 9th pulse `irq_flag` is set and `busy` drops. SCL is then held low.
- R6: Every SCL half period lasts reload+1 clock cycles. The reload value is bits 6:0 of register 2, and bit 7 has no effect.
- R7: The tick counter produces no ticks while no phase runs, so SCL does not toggle while idle.
- R8: Writing 1 to bit 2 (STOP) of register 1 drives SDA low and raises SCL. SDA then rises while SCL is high. Both lines end released, the STOP bit self-clears and `irq_flag` is set.
- R9: Writing 1 to bit 1 (repeated START) of register 1 after a byte releases SDA and raises SCL. SDA then falls while SCL is high, and SCL ends driven low with no STOP seen on the bus.
- R10: `irq_flag` stays set until a write of 1 to bit 3 of register 1. If a phase ends in the same cycle as that write, the flag is set.
- R11: A write to register 0 while a phase runs is ignored and does not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 command, 2 reload |
| wr_data | input | 8 | Write data |
| irq_flag | output | 1 | Sticky phase-complete flag |
| ack_stat | output | 1 | Last sampled acknowledge level |
| cmd_pend | output | 3 | Pending STOP, repeated START and START bits |
| busy | output | 1 | A bus phase is in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL pin level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA pin level |

## Verification
The hardest case to reach from the ports is a data-register write that lands in the middle of a byte. Catching it needs a bus-side observer that rebuilds the shifted byte from the pin levels. The bench pairs that observer with a slave model that detects START and STOP conditions, clocks in eight bits, and drives an acknowledge or no-acknowledge during the ninth pulse. It also timestamps SCL rising edges, so the half-period length can be checked against each reload value in the vector table, including one with bit 7 set.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_COND_START,
        PH_SHIFT,
        PH_COND_STOP
    } phase_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } lines_t;

    localparam int STEP_W = 5;
    localparam int BYTE_W = 8;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CMD  = 2'd1;
    localparam logic [1:0] REG_BAUD = 2'd2;

    localparam int CMD_START  = 0;
    localparam int CMD_RSTART = 1;
    localparam int CMD_STOP   = 2;
    localparam int CMD_IRQCLR = 3;

    localparam logic [STEP_W-1:0] LAST_COND  = 5'd2;
    localparam logic [STEP_W-1:0] LAST_SHIFT = 5'd17;

    function automatic logic [STEP_W-1:0] last_step(input phase_e ph);
        return (ph == PH_SHIFT) ? LAST_SHIFT : LAST_COND;
    endfunction

    // Line levels for one half period of a phase
    function automatic lines_t step_levels(input phase_e ph,
                                           input logic [STEP_W-1:0] step,
                                           input logic [BYTE_W-1:0] data);
        lines_t lv;
        logic [3:0] idx;
        idx = step[4:1];
        lv  = '{sda: 1'b1, scl: 1'b1};
        case (ph)
            PH_COND_START: begin
                case (step)
                    5'd0:    lv = '{sda: 1'b1, scl: 1'b0};
                    5'd1:    lv = '{sda: 1'b1, scl: 1'b1};
                    default: lv = '{sda: 1'b0, scl: 1'b1};
                endcase
            end
            PH_SHIFT: begin
                lv.sda = (idx < 4'd8) ? data[3'd7 - idx[2:0]] : 1'b1;
                lv.scl = step[0];
            end
            PH_COND_STOP: begin
                case (step)
                    5'd0:    lv = '{sda: 1'b0, scl: 1'b0};
                    5'd1:    lv = '{sda: 1'b0, scl: 1'b1};
                    default: lv = '{sda: 1'b1, scl: 1'b1};
                endcase
            end
            default: lv = '{sda: 1'b1, scl: 1'b1};
        endcase
        return lv;
    endfunction

    // Levels left on the bus once a phase has finished
    function automatic lines_t final_levels(input phase_e ph);
        case (ph)
            PH_COND_START: return '{sda: 1'b0, scl: 1'b0};
            PH_SHIFT:      return '{sda: 1'b1, scl: 1'b0};
            default:       return '{sda: 1'b1, scl: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
    parameter int RELOAD_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    logic [RELOAD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq
    import i2c_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go_start,
    input  logic              go_byte,
    input  logic              go_stop,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sda_in,
    output phase_e            phase,
    output phase_e            done_ph,
    output logic              done,
    output logic              ack_bit,
    output logic              sda_oe,
    output logic              scl_oe
);
    phase_e              phase_q;
    phase_e              done_ph_q;
    logic [STEP_W-1:0]   step_q;
    logic [BYTE_W-1:0]   shreg_q;
    lines_t              lv_q;
    logic                done_q;
    logic                ack_q;
    logic [STEP_W-1:0]   step_nx;

    assign step_nx = step_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            done_ph_q <= PH_IDLE;
            step_q    <= '0;
            shreg_q   <= '0;
            lv_q      <= '{sda: 1'b1, scl: 1'b1};
            done_q    <= 1'b0;
            ack_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                step_q <= '0;
                if (go_start) begin
                    phase_q <= PH_COND_START;
                    lv_q    <= step_levels(PH_COND_START, '0, shreg_q);
                end else if (go_byte) begin
                    phase_q <= PH_SHIFT;
                    shreg_q <= byte_in;
                    lv_q    <= step_levels(PH_SHIFT, '0, byte_in);
                end else if (go_stop) begin
                    phase_q <= PH_COND_STOP;
                    lv_q    <= step_levels(PH_COND_STOP, '0, shreg_q);
                end
            end else if (tick) begin
                if (step_q == last_step(phase_q)) begin
                    lv_q      <= final_levels(phase_q);
                    phase_q   <= PH_IDLE;
                    done_q    <= 1'b1;
                    done_ph_q <= phase_q;
                    if (phase_q == PH_SHIFT) begin
                        ack_q <= sda_in;
                    end
                end else begin
                    step_q <= step_nx;
                    lv_q   <= step_levels(phase_q, step_nx, shreg_q);
                end
            end
        end
    end

    assign phase   = phase_q;
    assign done_ph = done_ph_q;
    assign done    = done_q;
    assign ack_bit = ack_q;
    assign sda_oe  = !lv_q.sda;
    assign scl_oe  = !lv_q.scl;
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
    import i2c_step_pkg::*;
#(
    parameter int RELOAD_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       irq_flag,
    output logic       ack_stat,
    output logic [2:0] cmd_pend,
    output logic       busy,
    output logic       scl_oe,
    input  logic       scl_in,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int CMD_N = 3;

    logic [RELOAD_W-1:0] reload_q;
    logic [CMD_N-1:0]    pend_q;
    logic [CMD_N-1:0]    pend_clr;
    logic                irq_q;
    logic                tick;
    logic                seq_done;
    logic                ack_bit;
    logic                can_launch;
    logic                go_start;
    logic                go_byte;
    logic                go_stop;
    logic                clr_req;
    logic                scl_seen;
    phase_e              seq_phase;
    phase_e              done_ph;

    assign can_launch = (seq_phase == PH_IDLE) && !seq_done;
    assign go_start   = can_launch && (pend_q[CMD_START] || pend_q[CMD_RSTART]);
    assign go_stop    = can_launch && pend_q[CMD_STOP];
    assign go_byte    = can_launch && (pend_q == '0) && wr_en && (wr_addr == REG_DATA);
    assign clr_req    = wr_en && (wr_addr == REG_CMD) && wr_data[CMD_IRQCLR];
    assign scl_seen   = scl_in;

    always_comb begin
        pend_clr = '0;
        if (seq_done && done_ph == PH_COND_START) begin
            pend_clr[CMD_START]  = 1'b1;
            pend_clr[CMD_RSTART] = 1'b1;
        end
        if (seq_done && done_ph == PH_COND_STOP) begin
            pend_clr[CMD_STOP] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            pend_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_en && wr_addr == REG_BAUD) begin
                reload_q <= wr_data[RELOAD_W-1:0];
            end
            if (wr_en && wr_addr == REG_CMD) begin
                pend_q <= (pend_q & ~pend_clr) | wr_data[CMD_N-1:0];
            end else begin
                pend_q <= pend_q & ~pend_clr;
            end
            if (seq_done) begin
                irq_q <= 1'b1;
            end else if (clr_req) begin
                irq_q <= 1'b0;
            end
        end
    end

    i2c_baud_tick #(.RELOAD_W(RELOAD_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (seq_phase != PH_IDLE),
        .reload (reload_q),
        .tick   (tick)
    );

    i2c_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .go_start (go_start),
        .go_byte  (go_byte),
        .go_stop  (go_stop),
        .byte_in  (wr_data),
        .sda_in   (sda_in),
        .phase    (seq_phase),
        .done_ph  (done_ph),
        .done     (seq_done),
        .ack_bit  (ack_bit),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe)
    );

    assign irq_flag = irq_q;
    assign ack_stat = ack_bit;
    assign cmd_pend = pend_q;
    assign busy     = (seq_phase != PH_IDLE);
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk
    import i2c_step_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input phase_e seq_phase,
    input phase_e done_ph,
    input logic   seq_done,
    input logic   tick,
    input logic   busy,
    input logic   irq_flag,
    input logic   clr_req,
    input logic   sda_oe,
    input logic   scl_oe
);
    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (seq_phase == PH_SHIFT && $past(seq_phase == PH_SHIFT) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R3

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> irq_flag); // R5

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tick); // R7

    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        (seq_done && done_ph == PH_COND_STOP) |-> (!sda_oe && !scl_oe)); // R8

    AST_START_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
        (seq_done && done_ph == PH_COND_START) |-> (sda_oe && scl_oe)); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_req) |=> irq_flag); // R10
endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .seq_phase (seq_phase),
    .done_ph   (done_ph),
    .seq_done  (seq_done),
    .tick      (tick),
    .busy      (busy),
    .irq_flag  (irq_flag),
    .clr_req   (clr_req),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe)
);

// File: tb/i2c_step_master_tb.sv
module i2c_step_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_flag, ack_stat, busy, scl_oe, sda_oe;
    logic [2:0] cmd_pend;
    logic       slv_low = 1'b0;
    logic       ack_en = 1'b1;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_low);

    always #2.5 clk = ~clk;

    i2c_step_master u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_flag(irq_flag), .ack_stat(ack_stat), .cmd_pend(cmd_pend), .busy(busy),
        .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    // Slave model on the bus pins
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         bitcnt = 100;
    logic [7:0] shf = 8'd0, rx_byte = 8'd0;
    int         n_start = 0, n_stop = 0, n_rise = 0;
    int         t0 = 0, t1 = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        p_scl <= scl_line;
        p_sda <= sda_line;
        if (!rst) begin
            if (scl_line && p_scl && p_sda && !sda_line) begin
                n_start <= n_start + 1;
                bitcnt  <= 0;
                slv_low <= 1'b0;
            end else if (scl_line && p_scl && !p_sda && sda_line) begin
                n_stop <= n_stop + 1;
            end else if (scl_line && !p_scl) begin
                n_rise <= n_rise + 1;
                if (bitcnt == 0) t0 <= cyc;
                if (bitcnt == 1) t1 <= cyc;
                if (bitcnt < 8) shf <= {shf[6:0], sda_line};
                if (bitcnt < 50) bitcnt <= bitcnt + 1;
            end else if (!scl_line && p_scl) begin
                if (bitcnt == 8) slv_low <= ack_en;
                if (bitcnt == 9) begin
                    slv_low <= 1'b0;
                    rx_byte <= shf;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int k;
        k = 0;
        while (!irq_flag && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(req, int'(irq_flag), 1);
    endtask

    // {ack_en, reload register value, data byte}
    localparam logic [16:0] VEC [4] = '{
        {1'b1, 8'h01, 8'hA5},
        {1'b0, 8'h03, 8'h3C},
        {1'b1, 8'h82, 8'h81},
        {1'b1, 8'h00, 8'h7E}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s0, p0, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 irq", int'(irq_flag), 0);
        check("R1 ack", int'(ack_stat), 0);
        check("R1 pend", int'(cmd_pend), 0);
        check("R1 busy", int'(busy), 0);

        foreach (VEC[i]) begin
            ack_en = VEC[i][16];
            wr(2'd2, VEC[i][15:8]);
            s0 = n_start;
            wr(2'd1, 8'h01);
            wait_irq("R2 irq after START");
            check("R2 start seen", n_start, s0 + 1);
            check("R2 pend cleared", int'(cmd_pend), 0);
            wr(2'd1, 8'h08);
            check("R10 irq cleared", int'(irq_flag), 0);
            wr(2'd0, VEC[i][7:0]);
            wait_irq("R5 irq after byte");
            @(negedge clk);
            check("R3 byte on bus", int'(rx_byte), int'(VEC[i][7:0]));
            check("R4 ack status", int'(ack_stat), int'(!VEC[i][16]));
            check("R6 SCL period", t1 - t0, 2 * (int'(VEC[i][14:8]) + 1));
            check("R5 busy low", int'(busy), 0);
            check("R5 scl held low", int'(scl_line), 0);
            wr(2'd1, 8'h08);
            p0 = n_stop;
            wr(2'd1, 8'h04);
            wait_irq("R8 irq after STOP");
            @(negedge clk);
            check("R8 stop seen", n_stop, p0 + 1);
            check("R8 lines released", int'({scl_line, sda_line}), 3);
            check("R8 pend cleared", int'(cmd_pend), 0);
            wr(2'd1, 8'h08);
        end

        // R10 sticky flag, R11 write during a byte
        ack_en = 1'b1;
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h01);
        wait_irq("R2 irq");
        repeat (40) @(negedge clk);
        check("R10 irq stays set", int'(irq_flag), 1);
        wr(2'd1, 8'h08);
        wr(2'd0, 8'hC3);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h00);
        wait_irq("R11 irq");
        @(negedge clk);
        check("R11 byte not altered", int'(rx_byte), 8'hC3);
        wr(2'd1, 8'h08);

        // R7 idle: no SCL activity
        r0 = n_rise;
        repeat (100) @(negedge clk);
        check("R7 no SCL edges idle", n_rise, r0);
        check("R7 scl still low", int'(scl_line), 0);

        // R9 repeated START keeps the bus
        s0 = n_start; p0 = n_stop;
        wr(2'd1, 8'h02);
        wait_irq("R9 irq");
        check("R9 start seen", n_start, s0 + 1);
        check("R9 no stop", n_stop, p0);
        check("R9 scl driven", int'(scl_oe), 1);
        wr(2'd1, 8'h08);
        ack_en = 1'b0;
        wr(2'd0, 8'h55);
        wait_irq("R4 irq");
        @(negedge clk);
        check("R4 nack captured", int'(ack_stat), 1);
        check("R3 second byte", int'(rx_byte), 8'h55);
        wr(2'd1, 8'h08);
        wr(2'd1, 8'h04);
        wait_irq("R8 irq");
        @(negedge clk);
        check("R8 final release", int'({scl_line, sda_line}), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule